// File: doc/BRIEF.md
# Single-Precision to Narrow Float Converter

This block takes IEEE single-precision words and narrows each one to a 16-bit brain-float value or to one of two 8-bit float formats. The format is chosen per word: one with 4 exponent bits and 3 mantissa bits, or one with 5 exponent bits and 2 mantissa bits. Each word carries its own format code and its own rounding-mode bit. Rounding is either round-to-nearest with ties to even, or stochastic. In stochastic mode a 16-bit random word supplied alongside the data decides whether the discarded fraction rounds up.

Words enter and leave on valid/ready handshakes. Two register stages separate input from output. Overflow, underflow into subnormals, signed zero, infinities and NaN are resolved per format, so the downstream logic only ever sees legal encodings.

Top module: `fp32_narrow_cvt`

## Requirements
- R1: `in_fmt` picks the target format: 0 gives the 16-bit brain float in `out_data[15:0]`; 1 gives the 4-exponent/3-mantissa byte (bias 7); 2 gives the 5-exponent/2-mantissa byte (bias 15); 3 is treated as 0. For byte formats the result sits in `out_data[7:0]` with the sign in bit 7, and `out_data[15:8]` is zero.
- R2: For format 0 the sign and the 8-bit exponent pass through unchanged. The mantissa is rounded to 7 bits, nearest with ties to even, and a rounding carry propagates into the exponent.
- R3: For format 1 there is no infinity. Finite overflow and input infinities saturate to ±448 (magnitude code 0x7E), and NaN encodes as magnitude 0x7F.
- R4: For format 2, overflow and input infinities give ±infinity (magnitude 0x7C), and NaN gives magnitude 0x7E.
- R5: For format 0, infinity gives magnitude 0x7F80 and NaN gives magnitude 0x7FC0. A NaN input never leaves as a non-NaN in any format.
- R6: Values below the target's smallest normal are rounded into subnormal codes or signed zero. Single-precision subnormal inputs are handled the same way.
- R7: With `in_stoch`=1, let d be the number of discarded significand bits. The magnitude rounds up when (discarded bits + `in_rand` shifted left by d-16) is at least 2^d. With `in_rand`=0 this truncates.
- R8: A word accepted at clock edge N shows on `out_valid` after edge N+1. Throughput is one word per cycle while `out_ready` is high, and `in_ready` is high whenever the output stage is empty.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` holds steady and no word is lost or reordered.
- R10: Format, rounding mode and random word are captured together with the data word they accompany.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Converter can take a word |
| in_data | input | 32 | Single-precision input |
| in_fmt | input | 2 | Target format code |
| in_stoch | input | 1 | 1 = stochastic rounding, 0 = nearest-even |
| in_rand | input | 16 | Random word for stochastic rounding |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Narrowed result |

## Verification
Directed vectors cover the cases below, and each has a typical failure:
- Exact halfway ties: a converter that always rounds halves up shows an odd mantissa.
- Mantissa carries that must bump the exponent: a narrow adder wraps the mantissa to zero.
- Overflow in the byte formats: the 3-bit-mantissa format must clamp to 448, not emit its NaN code; the other byte format must give infinity, not a wrapped finite value.
- Deep underflow and single-precision subnormals: these expose a shift that loses the implicit one.
- Stochastic words at both extremes: these show whether the random word is aligned with the discarded bits.

Randomized traffic across all formats then runs under random back-pressure, which catches dropped, duplicated or mixed-up words and format codes.

// File: rtl/fp32_narrow_cvt.sv
module fp32_narrow_cvt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic [1:0]  in_fmt,
  input  logic        in_stoch,
  input  logic [15:0] in_rand,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_data
);

  function automatic logic [15:0] narrow(input logic [31:0] x, input logic [1:0] f,
                                         input logic st, input logic [15:0] rn);
    int          mb, bias, te, d;
    logic [63:0] sig, kept, rem, mag, lim, one_d;
    logic        sat, up;
    logic [15:0] nan_c, inf_c, sbit;
    case (f)
      2'd1:    begin mb = 3; bias = 7;   lim = 64'd126;   sat = 1'b1; nan_c = 16'h007F; inf_c = 16'h007E; end
      2'd2:    begin mb = 2; bias = 15;  lim = 64'd123;   sat = 1'b0; nan_c = 16'h007E; inf_c = 16'h007C; end
      default: begin mb = 7; bias = 127; lim = 64'h7F7F;  sat = 1'b0; nan_c = 16'h7FC0; inf_c = 16'h7F80; end
    endcase
    sbit = !x[31] ? 16'h0000 : ((f == 2'd1 || f == 2'd2) ? 16'h0080 : 16'h8000);
    if (x[30:23] == 8'hFF)
      return sbit | ((x[22:0] != 23'd0) ? nan_c : inf_c);
    sig   = {40'd0, |x[30:23], x[22:0]};
    te    = ((x[30:23] == 8'd0) ? 1 : int'({24'd0, x[30:23]})) - 127 + bias;
    d     = 23 - mb + ((te < 1) ? 1 - te : 0);
    if (d > 40) d = 40;
    one_d = 64'd1 << d;
    kept  = sig >> d;
    rem   = sig & (one_d - 64'd1);
    if (st) up = (rem + (64'(rn) << (d - 16))) >= one_d;
    else    up = (rem > (one_d >> 1)) || ((rem == (one_d >> 1)) && kept[0]);
    mag = kept + 64'(up) + ((te > 1) ? (64'(te - 1) << mb) : 64'd0);
    if (mag > lim) mag = sat ? lim : 64'(inf_c);
    return sbit | mag[15:0];
  endfunction

  logic        v1, v2, adv2;
  logic [31:0] d1;
  logic [1:0]  f1;
  logic        s1;
  logic [15:0] r1, q2;

  assign adv2      = !v2 || out_ready;
  assign in_ready  = !v1 || adv2;
  assign out_valid = v2;
  assign out_data  = q2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      if (in_ready) v1 <= in_valid;
      if (adv2)     v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      d1 <= in_data;
      f1 <= in_fmt;
      s1 <= in_stoch;
      r1 <= in_rand;
    end
    if (adv2 && v1) q2 <= narrow(d1, f1, s1, r1);
  end

endmodule

module fp32_narrow_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_data,
  input logic [1:0]  in_fmt,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8
  AST_TWO_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2)); // R8
  AST_E4M3_NO_NAN_FROM_NUM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && $past(in_fmt, 2) == 2'd1 && $past(in_data[30:23], 2) != 8'hFF
    |-> out_data[6:0] != 7'h7F && out_data[15:8] == 8'd0); // R3
  AST_E5M2_NAN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && $past(in_fmt, 2) == 2'd2 && $past(in_data[30:0], 2) > 31'h7F800000
    |-> out_data[6:2] == 5'h1F && out_data[1:0] != 2'b00); // R5
endmodule

bind fp32_narrow_cvt fp32_narrow_cvt_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_fmt(in_fmt), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/fp32_narrow_cvt_tb_top.sv
module fp32_narrow_cvt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_stoch = 1'b0, out_ready = 1'b1;
  logic [31:0] in_data = '0;
  logic [1:0]  in_fmt = '0;
  logic [15:0] in_rand = '0;
  logic        in_ready, out_valid;
  logic [15:0] out_data;
  int          total = 0, bad = 0;
  bit          rand_rdy = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  string       cur_tag = "R1";
  bit          stalled = 1'b0;
  logic [15:0] stall_val;

  always #2 clk = ~clk;

  fp32_narrow_cvt dut_i (.*);

  function automatic logic [15:0] ref_cvt(logic [31:0] x, logic [1:0] f, logic st, logic [15:0] rn);
    int mb, bias, eu, lo, d, ef;
    longint unsigned sig, n, rem, code, maxc;
    bit up, b8;
    b8   = (f == 2'd1 || f == 2'd2);
    mb   = f == 2'd1 ? 3 : f == 2'd2 ? 2 : 7;
    bias = f == 2'd1 ? 7 : f == 2'd2 ? 15 : 127;
    maxc = f == 2'd1 ? 126 : f == 2'd2 ? 123 : 32639;
    if (x[30:23] == 8'hFF) begin
      if (x[22:0] != 0) code = f == 2'd1 ? 'h7F : f == 2'd2 ? 'h7E : 'h7FC0;
      else              code = f == 2'd1 ? 126 : f == 2'd2 ? 'h7C : 'h7F80;
    end else begin
      eu  = (x[30:23] == 0) ? -126 : int'(x[30:23]) - 127;
      lo  = (eu >= 1 - bias) ? eu : 1 - bias;
      d   = lo - eu + 23 - mb;
      sig = {x[30:23] != 0, x[22:0]};
      if (d >= 40) begin n = 0; up = 0; end
      else begin
        n   = sig >> d;
        rem = sig - (n << d);
        if (st) up = (rem + (longint'(rn) << (d - 16))) >= (64'd1 << d);
        else    up = (2 * rem > (64'd1 << d)) || (2 * rem == (64'd1 << d) && n[0]);
      end
      n  = n + up;
      ef = (eu >= 1 - bias && x[30:23] != 0) ? eu + bias : 0;
      if (ef == 0) code = n;
      else begin
        if (n >= (64'd1 << (mb + 1))) begin ef++; n = n >> 1; end
        code = (longint'(ef) << mb) | (n - (64'd1 << mb));
      end
      if (code > maxc) code = f == 2'd1 ? 126 : f == 2'd2 ? 'h7C : 'h7F80;
    end
    if (x[31]) code = code | (b8 ? 'h80 : 'h8000);
    return code[15:0];
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // scoreboard: acceptance and delivery seen at negedge, take effect at next posedge
  always @(negedge clk) if (rst_n) begin
    if (in_valid && in_ready) begin
      exp_q.push_back(ref_cvt(in_data, in_fmt, in_stoch, in_rand));
      tag_q.push_back(cur_tag);
    end
    if (stalled) begin
      total++;
      if (!out_valid || out_data !== stall_val) begin
        bad++;
        $display("FAIL R9 actual=%b/%h expected=1/%h", out_valid, out_data, stall_val);
      end
    end
    stalled = out_valid && !out_ready;
    stall_val = out_data;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 actual=extra word %h expected=none", out_data);
      end else chk(tag_q.pop_front(), out_data, exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    #1;
    if (rand_rdy) out_ready = ($urandom % 3) != 0;
  end

  task automatic send(logic [31:0] x, logic [1:0] f, logic st, logic [15:0] rn, string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = x; in_fmt = f; in_stoch = st; in_rand = rn; cur_tag = tag;
    forever begin @(negedge clk); if (in_ready) break; end
    @(posedge clk); #1;
    in_valid = 1'b0; in_data = $urandom; in_fmt = 2'($urandom); in_rand = 16'($urandom);
  endtask

  task automatic drain();
    repeat (40) @(posedge clk);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset out_valid", {15'd0, out_valid}, 16'd0);
    chk("R8 reset in_ready", {15'd0, in_ready}, 16'd1);

    // latency: accepted at edge P, visible after P+1
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = 32'h3F800000; in_fmt = 2'd1; in_stoch = 1'b0; cur_tag = "R1";
    @(negedge clk);
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk); chk("R8 latency edge1", {15'd0, out_valid}, 16'd0);
    @(negedge clk); chk("R8 latency edge2", {15'd0, out_valid}, 16'd1);
    drain();

    send(32'h3F800000, 2'd0, 0, 0, "R1 bf16 one");
    send(32'h3F800000, 2'd2, 0, 0, "R1 e5m2 one");
    send(32'hBF800000, 2'd3, 0, 0, "R1 code3 as bf16");
    send(32'h3F808000, 2'd0, 0, 0, "R2 tie even down");
    send(32'h3F818000, 2'd0, 0, 0, "R2 tie even up");
    send(32'h3FFFFFFF, 2'd0, 0, 0, "R2 carry into exponent");
    send(32'h7F7FFFFF, 2'd0, 0, 0, "R5 bf16 overflow to inf");
    send(32'h49742400, 2'd1, 0, 0, "R3 e4m3 saturate 448");
    send(32'hFF800000, 2'd1, 0, 0, "R3 e4m3 -inf saturates");
    send(32'h7FC00000, 2'd1, 0, 0, "R3 e4m3 nan");
    send(32'h47800000, 2'd2, 0, 0, "R4 e5m2 overflow inf");
    send(32'hFFC00001, 2'd2, 0, 0, "R4 e5m2 nan");
    send(32'h7F800001, 2'd0, 0, 0, "R5 bf16 nan");
    send(32'h3B000000, 2'd1, 0, 0, "R6 e4m3 min subnormal");
    send(32'h3A800000, 2'd1, 0, 0, "R6 e4m3 half min tie to zero");
    send(32'h80000001, 2'd0, 0, 0, "R6 fp32 subnormal to bf16");
    send(32'h80000000, 2'd2, 0, 0, "R6 negative zero");
    send(32'h3F80FFFF, 2'd0, 1, 16'h0000, "R7 stochastic zero rand truncates");
    send(32'h3F800001, 2'd0, 1, 16'hFFFF, "R7 stochastic max rand rounds up");
    send(32'h3F900000, 2'd1, 1, 16'h8000, "R7 stochastic half");
    send(32'h00000001, 2'd2, 1, 16'hFFFF, "R7 deep underflow stochastic");
    drain();

    rand_rdy = 1'b1;
    for (int i = 0; i < 600; i++) begin
      logic [1:0]  f;
      logic [7:0]  e;
      logic [31:0] x;
      f = 2'($urandom);
      case (f)
        2'd1:    e = 8'(115 + $urandom % 24);
        2'd2:    e = 8'(105 + $urandom % 40);
        default: e = 8'($urandom);
      endcase
      if ($urandom % 20 == 0) e = 8'hFF;
      if ($urandom % 20 == 0) e = 8'h00;
      x = {1'($urandom), e, 23'($urandom)};
      send(x, f, 1'($urandom), 16'($urandom),
           f == 2'd1 ? "R10 rand e4m3" : f == 2'd2 ? "R10 rand e5m2" : "R10 rand bf16");
    end
    rand_rdy = 1'b0;
    @(posedge clk); #1 out_ready = 1'b1;
    drain();
    chk("R9 queue drained", 16'(exp_q.size()), 16'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule